// File: doc/BRIEF.md
# Dual-Channel PCM Serial Port

This block is the serial front end between a two-channel voice processor and external codecs. It moves 8-bit companded samples over four data lines per direction pair: a reference-side receive line and a send-side receive line come in, and a reference-side transmit line and a send-side transmit line go out, for each of two lanes. Every frame is marked by an 8 kHz sync pulse and paced by a slow bit clock. Both the bit clock and the sync are oversampled by the fast system clock. Received bytes are handed to the core through parallel registers together with a one-cycle strobe per channel. Transmit bytes are taken from parallel inputs at the start of each slot.

A two-bit mode input picks the wiring. In the independent mode, each lane is a channel with its own sync. In the multiplexed mode, both channels share lane 0 in two consecutive 8-bit slots and lane 1 is idle. In the cross-connected mode, both lanes run from sync A, only the send-side inputs and reference-side outputs are used, and the send-side outputs stay released. The fourth code is inhibited. Outputs are split into a data bit and a drive enable, so the pad ring can build the tri-state buffers.

Top module: `pcm_duplex_port`

## Requirements
- R1: mode_i selects the wiring: 2'b00 independent lanes (lane 0 = channel A framed by sync_a_i, lane 1 = channel B framed by sync_b_i), 2'b01 multiplexed, 2'b10 cross-connected, 2'b11 inhibited.
- R2: A frame starts at the bit-clock falling edge where the sync is first seen high. The next rising edge drives bit 7 (MSB first), and each following rising edge drives the next lower bit. Inputs are captured on falling edges in the same bit order.
- R3: In multiplexed mode, channel A occupies bit times 0 to 7 and channel B bit times 8 to 15 after sync_a_i, all on lane 0. The lane 1 drive enables stay low and the lane 1 inputs are ignored.
- R4: In cross-connected mode, both lanes are framed by sync_a_i. Both s_drive_o bits stay low, the reference-side inputs are ignored (received reference bytes read 8'h00), and both reference-side outputs and send-side inputs are active.
- R5: With mode 2'b11, all drive enables stay low and no receive strobe occurs.
- R6: A drive enable is high only from the rising edge that drives a slot's first bit to the rising edge after the frame's last bit, where it is released.
- R7: While rst_n is low, all drive enables and receive strobes are low. A frame cut by reset produces no strobe.
- R8: After a channel's eighth bit is captured, rx_valid_o for that channel is high for exactly one clk cycle, with rx_r_o and rx_s_o holding the received bytes. Bit 0 of the vectors is channel A.
- R9: The transmit bytes for a slot are taken when the slot's first bit is driven. Later changes to tx_r_i or tx_s_i do not affect that slot.
- R10: A new sync seen in the middle of a frame restarts the bit count. The partly received bytes are dropped without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | Wiring mode code |
| bclk_i | input | 1 | PCM bit clock |
| sync_a_i | input | 1 | Frame sync for lane 0 (and for both lanes in cross-connected mode) |
| sync_b_i | input | 1 | Frame sync for lane 1 in independent mode |
| r_line_i | input | 2 | Reference-side serial inputs, one per lane |
| s_line_i | input | 2 | Send-side serial inputs, one per lane |
| tx_r_i | input | 2x8 | Reference-side transmit bytes per channel |
| tx_s_i | input | 2x8 | Send-side transmit bytes per channel |
| r_line_o | output | 2 | Reference-side serial data out per lane |
| s_line_o | output | 2 | Send-side serial data out per lane |
| r_drive_o | output | 2 | Drive enables for r_line_o |
| s_drive_o | output | 2 | Drive enables for s_line_o |
| rx_r_o | output | 2x8 | Received reference-side bytes per channel |
| rx_s_o | output | 2x8 | Received send-side bytes per channel |
| rx_valid_o | output | 2 | One-cycle receive strobe per channel |

## Verification
A corrupted bit or slot counter shows up within one bit time as a wrong data bit on a driven line, a drive enable that rises or falls on the wrong edge, or a strobe that comes early, comes twice, or never comes. A wrong mode decode shows up on the first frame as an enable on an idle lane or a byte delivered to the wrong channel. A stale transmit shift register shows up as a shifted byte in the same frame. The bench checks every bit of every frame and queues the expected received bytes, so each of these faults is reported in the frame where it occurs.

// File: rtl/pcm_port_pkg.sv
// Shared definitions for the dual-channel PCM serial port.
// Assumes a two-bit mode code driven from static configuration.
package pcm_port_pkg;
    typedef enum logic [1:0] {
        MODE_PAR  = 2'b00,
        MODE_MUX  = 2'b01,
        MODE_XCON = 2'b10,
        MODE_OFF  = 2'b11
    } pcm_mode_e;

    localparam int LANES     = 2;
    localparam int SLOTS_MAX = 2;
endpackage

// File: rtl/pcm_in_sync.sv
// Multi-stage synchronizer for slow asynchronous inputs.
// Assumes every input changes far less often than once per STAGES clocks;
// all bits pass through the same depth, so their relative timing is kept.
module pcm_in_sync #(
    parameter int WIDTH  = 7,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        // Shift the inputs one stage deeper each clock.
        always_ff @(posedge clk) begin
            if (!rst_n)
                chain[g] <= '0;
            else if (g == 0)
                chain[g] <= d_i;
            else
                chain[g] <= chain[(g == 0) ? 0 : g-1];
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/pcm_slot_engine.sv
// Bit and slot sequencer for one lane: one reference-side and one send-side
// line in each direction. A frame holds last_slot_i+1 slots of SAMPLE_W bits.
// Assumes single-cycle bit-clock edge pulses; a rise and a fall never coincide.
module pcm_slot_engine #(
    parameter int SAMPLE_W  = 8,
    parameter int SLOTS_MAX = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                en_i,
    input  logic [$clog2(SLOTS_MAX)-1:0]        last_slot_i,
    input  logic                                rise_i,
    input  logic                                fall_i,
    input  logic                                sync_i,
    input  logic                                r_in_i,
    input  logic                                s_in_i,
    input  logic [SLOTS_MAX-1:0][SAMPLE_W-1:0]  tx_r_i,
    input  logic [SLOTS_MAX-1:0][SAMPLE_W-1:0]  tx_s_i,
    output logic                                r_out_o,
    output logic                                s_out_o,
    output logic                                drive_o,
    output logic [SAMPLE_W-1:0]                 rx_r_o,
    output logic [SAMPLE_W-1:0]                 rx_s_o,
    output logic                                rx_done_o,
    output logic [$clog2(SLOTS_MAX)-1:0]        rx_slot_o
);
    localparam int SLOT_W = $clog2(SLOTS_MAX);
    localparam int CNT_W  = $clog2(SAMPLE_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(SAMPLE_W - 1);

    logic              sync_prev_q;
    logic              active_q;
    logic              started_q;
    logic [SLOT_W-1:0] slot_q;
    logic [CNT_W-1:0]  pos_q;
    logic [SAMPLE_W-1:0] tr_sh, ts_sh, rr_sh, rs_sh;
    logic              sync_start;
    logic [SLOT_W-1:0] next_slot;

    assign sync_start = fall_i && sync_i && !sync_prev_q;
    assign next_slot  = slot_q + 1'b1;

    // Frame sequencing: restart on sync, capture on falls, shift out on rises.
    always_ff @(posedge clk) begin
        if (!rst_n || !en_i) begin
            sync_prev_q <= 1'b0;
            active_q    <= 1'b0;
            started_q   <= 1'b0;
            slot_q      <= '0;
            pos_q       <= '0;
            tr_sh       <= '0;
            ts_sh       <= '0;
            rr_sh       <= '0;
            rs_sh       <= '0;
            rx_r_o      <= '0;
            rx_s_o      <= '0;
            rx_done_o   <= 1'b0;
            rx_slot_o   <= '0;
        end else begin
            rx_done_o <= 1'b0;
            if (fall_i) begin
                sync_prev_q <= sync_i;
                if (sync_start) begin
                    active_q  <= 1'b1;
                    started_q <= 1'b0;
                    slot_q    <= '0;
                    pos_q     <= '0;
                end else if (started_q) begin
                    rr_sh <= {rr_sh[SAMPLE_W-2:0], r_in_i};
                    rs_sh <= {rs_sh[SAMPLE_W-2:0], s_in_i};
                    if (pos_q == LAST_BIT) begin
                        rx_r_o    <= {rr_sh[SAMPLE_W-2:0], r_in_i};
                        rx_s_o    <= {rs_sh[SAMPLE_W-2:0], s_in_i};
                        rx_done_o <= 1'b1;
                        rx_slot_o <= slot_q;
                    end
                end
            end
            if (rise_i && active_q) begin
                if (!started_q) begin
                    started_q <= 1'b1;
                    tr_sh     <= tx_r_i[0];
                    ts_sh     <= tx_s_i[0];
                end else if (pos_q == LAST_BIT) begin
                    if (slot_q == last_slot_i) begin
                        active_q  <= 1'b0;
                        started_q <= 1'b0;
                    end else begin
                        slot_q <= next_slot;
                        pos_q  <= '0;
                        tr_sh  <= tx_r_i[next_slot];
                        ts_sh  <= tx_s_i[next_slot];
                    end
                end else begin
                    pos_q <= pos_q + 1'b1;
                    tr_sh <= {tr_sh[SAMPLE_W-2:0], 1'b0};
                    ts_sh <= {ts_sh[SAMPLE_W-2:0], 1'b0};
                end
            end
        end
    end

    assign r_out_o = tr_sh[SAMPLE_W-1];
    assign s_out_o = ts_sh[SAMPLE_W-1];
    assign drive_o = started_q;

    // R10: a sync edge always rewinds the sequencer to bit 0 of slot 0.
    p_restart_r10: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        sync_start |=> (active_q && !started_q && pos_q == '0 && slot_q == '0));

    // R8: the completion pulse never lasts two cycles.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n || !en_i)
        rx_done_o |=> !rx_done_o);
endmodule

// File: rtl/pcm_duplex_port.sv
// Dual-channel PCM serial port top. It decodes the wiring mode, synchronizes
// the bit clock, syncs and data lines, runs one slot engine per lane and
// routes the received bytes to the per-channel registers.
// Assumes the bit clock is at least 4*SYNC_STAGES times slower than clk and
// that mode_i changes only between frames.
module pcm_duplex_port
    import pcm_port_pkg::*;
#(
    parameter int SAMPLE_W    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               mode_i,
    input  logic                     bclk_i,
    input  logic                     sync_a_i,
    input  logic                     sync_b_i,
    input  logic [1:0]               r_line_i,
    input  logic [1:0]               s_line_i,
    input  logic [1:0][SAMPLE_W-1:0] tx_r_i,
    input  logic [1:0][SAMPLE_W-1:0] tx_s_i,
    output logic [1:0]               r_line_o,
    output logic [1:0]               s_line_o,
    output logic [1:0]               r_drive_o,
    output logic [1:0]               s_drive_o,
    output logic [1:0][SAMPLE_W-1:0] rx_r_o,
    output logic [1:0][SAMPLE_W-1:0] rx_s_o,
    output logic [1:0]               rx_valid_o
);
    localparam int SLOT_W = $clog2(SLOTS_MAX);
    localparam int IN_W   = 3 + 2 * LANES;

    pcm_mode_e mode;
    assign mode = pcm_mode_e'(mode_i);

    logic [IN_W-1:0]  in_s;
    logic             bclk_s, bclk_d, sync_a_s, sync_b_s;
    logic [LANES-1:0] r_s, s_s;
    logic             rise, fall;

    pcm_in_sync #(.WIDTH(IN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({bclk_i, sync_a_i, sync_b_i, r_line_i, s_line_i}),
        .q_o   (in_s)
    );
    assign {bclk_s, sync_a_s, sync_b_s, r_s, s_s} = in_s;

    // Delay the synchronized bit clock by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_d <= 1'b0;
        else        bclk_d <= bclk_s;
    end
    assign rise = bclk_s && !bclk_d;
    assign fall = !bclk_s && bclk_d;

    logic [LANES-1:0]              en, esync, er_in, drv, rbit, sbit, done;
    logic [LANES-1:0][SLOT_W-1:0]  last_slot, done_slot;
    logic [LANES-1:0][SLOTS_MAX-1:0][SAMPLE_W-1:0] etx_r, etx_s;
    logic [LANES-1:0][SAMPLE_W-1:0] erx_r, erx_s;

    // Per-lane wiring chosen by the mode code.
    always_comb begin
        en[0]        = (mode != MODE_OFF);
        en[1]        = (mode == MODE_PAR) || (mode == MODE_XCON);
        last_slot[0] = (mode == MODE_MUX) ? SLOT_W'(1) : '0;
        last_slot[1] = '0;
        esync[0]     = sync_a_s;
        esync[1]     = (mode == MODE_XCON) ? sync_a_s : sync_b_s;
        for (int l = 0; l < LANES; l++) begin
            er_in[l] = (mode == MODE_XCON) ? 1'b0 : r_s[l];
            for (int s = 0; s < SLOTS_MAX; s++) begin
                etx_r[l][s] = (l == 0) ? tx_r_i[s] : tx_r_i[1];
                etx_s[l][s] = (l == 0) ? tx_s_i[s] : tx_s_i[1];
            end
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        pcm_slot_engine #(.SAMPLE_W(SAMPLE_W), .SLOTS_MAX(SLOTS_MAX)) u_eng (
            .clk         (clk),
            .rst_n       (rst_n),
            .en_i        (en[g]),
            .last_slot_i (last_slot[g]),
            .rise_i      (rise),
            .fall_i      (fall),
            .sync_i      (esync[g]),
            .r_in_i      (er_in[g]),
            .s_in_i      (s_s[g]),
            .tx_r_i      (etx_r[g]),
            .tx_s_i      (etx_s[g]),
            .r_out_o     (rbit[g]),
            .s_out_o     (sbit[g]),
            .drive_o     (drv[g]),
            .rx_r_o      (erx_r[g]),
            .rx_s_o      (erx_s[g]),
            .rx_done_o   (done[g]),
            .rx_slot_o   (done_slot[g])
        );
        assign r_line_o[g]  = rbit[g];
        assign s_line_o[g]  = sbit[g];
        assign r_drive_o[g] = drv[g];
        assign s_drive_o[g] = drv[g] && (mode != MODE_XCON);
    end

    // Route finished bytes to their channel registers and raise the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_r_o     <= '0;
            rx_s_o     <= '0;
            rx_valid_o <= '0;
        end else begin
            rx_valid_o <= '0;
            if (done[0] && en[0]) begin
                rx_r_o[done_slot[0]]     <= erx_r[0];
                rx_s_o[done_slot[0]]     <= erx_s[0];
                rx_valid_o[done_slot[0]] <= 1'b1;
            end
            if (done[1] && en[1]) begin
                rx_r_o[1]     <= erx_r[1];
                rx_s_o[1]     <= erx_s[1];
                rx_valid_o[1] <= 1'b1;
            end
        end
    end

    // R8: each channel strobe is a single-cycle pulse.
    p_strobe_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_o != '0) |=> ((rx_valid_o & $past(rx_valid_o)) == '0));

    // R3: lane 1 never drives in multiplexed mode.
    p_mux_lane1_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_MUX) |=> (!r_drive_o[1] && !s_drive_o[1]));

    // R5: the inhibited code leaves every output quiet.
    p_inhibit_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_OFF) |=> (r_drive_o == '0 && s_drive_o == '0 && rx_valid_o == '0));

    // R4: send-side outputs stay released in cross-connected mode.
    p_xcon_send_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_XCON) |-> (s_drive_o == '0));
endmodule

// File: tb/test_pcm_duplex_port.sv
module test_pcm_duplex_port;
    localparam int HALF = 8;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [1:0]      mode = 2'b00;
    logic            bclk = 1'b0, sync_a = 1'b0, sync_b = 1'b0;
    logic [1:0]      r_in = '0, s_in = '0;
    logic [1:0][7:0] tx_r = '0, tx_s = '0, tx_r_new = '0, tx_s_new = '0;
    logic [1:0]      r_out, s_out, r_drv, s_drv, rx_valid;
    logic [1:0][7:0] rx_r, rx_s;

    int checks = 0;
    int errors = 0;
    logic [15:0] q0 [$];
    logic [15:0] q1 [$];

    always #4 clk = ~clk;

    pcm_duplex_port i_pcm_duplex_port (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .bclk_i(bclk),
        .sync_a_i(sync_a), .sync_b_i(sync_b), .r_line_i(r_in), .s_line_i(s_in),
        .tx_r_i(tx_r), .tx_s_i(tx_s), .r_line_o(r_out), .s_line_o(s_out),
        .r_drive_o(r_drv), .s_drive_o(s_drv), .rx_r_o(rx_r), .rx_s_o(rx_s),
        .rx_valid_o(rx_valid)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the expected byte pair on every strobe.
    always @(negedge clk) begin
        if (rst_n === 1'b1) begin
            if (rx_valid[0]) begin
                if (q0.size() == 0) check(1'b0, "R8 unexpected strobe ch A", {16'h0, rx_r[0], rx_s[0]}, 32'h0);
                else begin
                    logic [15:0] e;
                    e = q0.pop_front();
                    check({rx_r[0], rx_s[0]} == e, "R8 ch A bytes", {16'h0, rx_r[0], rx_s[0]}, {16'h0, e});
                end
            end
            if (rx_valid[1]) begin
                if (q1.size() == 0) check(1'b0, "R8 unexpected strobe ch B", {16'h0, rx_r[1], rx_s[1]}, 32'h0);
                else begin
                    logic [15:0] e;
                    e = q1.pop_front();
                    check({rx_r[1], rx_s[1]} == e, "R8 ch B bytes", {16'h0, rx_r[1], rx_s[1]}, {16'h0, e});
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    // Driver: one full frame, with per-bit output checks and queued receive bytes.
    task automatic run_frame(input int nb, input logic [15:0] ra, input logic [15:0] sa,
                             input logic [15:0] rb, input logic [15:0] sb,
                             input bit sb_on, input int chg_at, input string tag);
        logic [3:0] ed;
        ed[0] = (mode != 2'b11);
        ed[1] = (mode == 2'b00) || (mode == 2'b10);
        ed[2] = (mode == 2'b00) || (mode == 2'b01);
        ed[3] = (mode == 2'b00);
        case (mode)
            2'b00: begin q0.push_back({ra[15:8], sa[15:8]}); q1.push_back({rb[15:8], sb[15:8]}); end
            2'b01: begin q0.push_back({ra[15:8], sa[15:8]}); q1.push_back({ra[7:0], sa[7:0]}); end
            2'b10: begin q0.push_back({8'h00, sa[15:8]}); q1.push_back({8'h00, sb[15:8]}); end
            default: ;
        endcase
        sync_a = 1'b1; sync_b = sb_on; bclk = 1'b1; tick(HALF);
        bclk = 1'b0; tick(HALF);
        sync_a = 1'b0; sync_b = 1'b0;
        for (int i = 0; i < nb; i++) begin
            int slot, k, ch0;
            logic [1:0][7:0] sr, ss;
            logic [3:0] ev, av, ad;
            r_in = {rb[15-i], ra[15-i]};
            s_in = {sb[15-i], sa[15-i]};
            bclk = 1'b1; tick(HALF);
            slot = i / 8; k = i % 8;
            ch0 = (mode == 2'b01) ? slot : 0;
            sr = (chg_at >= 0 && slot * 8 > chg_at) ? tx_r_new : tx_r;
            ss = (chg_at >= 0 && slot * 8 > chg_at) ? tx_s_new : tx_s;
            if (chg_at >= 0 && slot * 8 > chg_at) begin sr = tx_r_new; ss = tx_s_new; end
            ev = {ss[1][7-k], ss[ch0][7-k], sr[1][7-k], sr[ch0][7-k]};
            if (chg_at >= 0 && slot * 8 <= chg_at && i > chg_at) begin
                // slot began before the change: the latched old bytes still apply
                ev = {tx_s_old[1][7-k], tx_s_old[ch0][7-k], tx_r_old[1][7-k], tx_r_old[ch0][7-k]};
            end
            av = {s_drv, r_drv};
            ad = {s_out, r_out};
            check(av == ed, {tag, " drive enables"}, {28'h0, av}, {28'h0, ed});
            check(((ad ^ ev) & ed) == 4'h0, {tag, " data bit"}, {24'h0, ad, 4'h0}, {24'h0, ev, 4'h0});
            if (i == chg_at) begin tx_r_old = tx_r; tx_s_old = tx_s; tx_r = tx_r_new; tx_s = tx_s_new; end
            bclk = 1'b0; tick(HALF);
        end
        bclk = 1'b1; tick(HALF);
        check({s_drv, r_drv} == 4'h0, "R6 release after last bit", {28'h0, s_drv, r_drv}, 32'h0);
        bclk = 1'b0; tick(HALF);
        check(q0.size() == 0 && q1.size() == 0, {tag, " R8 strobes delivered"}, q0.size() + q1.size(), 0);
    endtask

    logic [1:0][7:0] tx_r_old = '0, tx_s_old = '0;

    // Start a frame and stop after nb bits without checking.
    task automatic partial_frame(input int nb);
        sync_a = 1'b1; sync_b = 1'b1; bclk = 1'b1; tick(HALF);
        bclk = 1'b0; tick(HALF);
        sync_a = 1'b0; sync_b = 1'b0;
        for (int i = 0; i < nb; i++) begin
            r_in = 2'b11; s_in = 2'b10;
            bclk = 1'b1; tick(HALF);
            bclk = 1'b0; tick(HALF);
        end
    endtask

    initial begin
        tick(5);
        check({s_drv, r_drv} == 4'h0, "R7 drives low in reset", {28'h0, s_drv, r_drv}, 32'h0);
        check(rx_valid == 2'b00, "R7 no strobe in reset", {30'h0, rx_valid}, 32'h0);
        rst_n = 1'b1; tick(4);

        // R1 R2 independent lanes, two patterns
        mode = 2'b00;
        tx_r = {8'hC3, 8'hA5}; tx_s = {8'h0F, 8'h81};
        run_frame(8, 16'hB400, 16'h6900, 16'h1E00, 16'hF000, 1'b1, -1, "R1 R2 par");
        tx_r = {8'h01, 8'hFE}; tx_s = {8'h7F, 8'h80};
        run_frame(8, 16'h0100, 16'h8000, 16'hFF00, 16'h5A00, 1'b1, -1, "R1 R2 par2");

        // R3 multiplexed, lane 1 inputs carry junk
        mode = 2'b01; tick(4);
        tx_r = {8'h3C, 8'h96}; tx_s = {8'hE1, 8'h47};
        run_frame(16, 16'hA55A, 16'h12EF, 16'hFFFF, 16'hFFFF, 1'b1, -1, "R3 mux");

        // R9 transmit bytes latched at slot start
        tx_r = {8'h11, 8'h22}; tx_s = {8'h33, 8'h44};
        tx_r_new = {8'hD8, 8'h6B}; tx_s_new = {8'h2C, 8'h9E};
        run_frame(16, 16'h0FF0, 16'hC33C, 16'h0000, 16'h0000, 1'b1, 2, "R9 latch");

        // R4 cross-connected, both lanes from sync A, reference inputs ignored
        mode = 2'b10; tick(4);
        tx_r = {8'h5D, 8'hB2}; tx_s = {8'hFF, 8'hFF};
        run_frame(8, 16'hFF00, 16'hC700, 16'hFF00, 16'h3800, 1'b0, -1, "R4 xcon");

        // R5 inhibited code
        mode = 2'b11; tick(4);
        run_frame(8, 16'hAA00, 16'h5500, 16'hAA00, 16'h5500, 1'b1, -1, "R5 inhibit");

        // R10 sync mid-frame restarts
        mode = 2'b00; tick(4);
        tx_r = {8'h9A, 8'h4E}; tx_s = {8'h27, 8'hF3};
        partial_frame(4);
        run_frame(8, 16'h7200, 16'hD900, 16'h0C00, 16'hE600, 1'b1, -1, "R10 restart");

        // R7 reset cuts a frame
        partial_frame(3);
        rst_n = 1'b0; tick(3);
        check({s_drv, r_drv} == 4'h0, "R7 drives drop in reset", {28'h0, s_drv, r_drv}, 32'h0);
        check(rx_valid == 2'b00, "R7 strobes low in reset", {30'h0, rx_valid}, 32'h0);
        bclk = 1'b1; tick(HALF); bclk = 1'b0; tick(HALF);
        rst_n = 1'b1; tick(4);
        check(q0.size() == 0 && q1.size() == 0, "R7 no strobe from cut frame", 0, 0);
        run_frame(8, 16'h4B00, 16'hB400, 16'h2D00, 16'hD200, 1'b1, -1, "R7 after reset");

        tick(20);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule